// File: doc/BRIEF.md
# Power domain gating controller

This block sequences a gated logic domain between fully powered and fully collapsed. Software drives it through a single 32-bit control/status word: one bit requests collapse, one hands the request over to an external trigger line, one skips the timed waits, and three 4-bit exponent fields set the step waits in reference clock cycles. A read-only status bit reports when the domain is completely on again.

Power switches are split into a small first group and a larger second group, so that inrush current is limited. A switch acknowledge input stands in for the analog switch fabric. The controller also drives a clock-disable line, an output clamp and an active-low domain reset. Collapse stops the clocks first, then clamps the outputs, then opens every switch. Restore closes the small group and then the large group, waits for the acknowledge, removes the clamp, pulses the domain reset and re-enables the clocks.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset the register reads 32'h8000_0000: status bit 31 = 1 and every other field 0. The outputs show the domain on: both switch enables 1, clock disable 0, clamp 0, domain reset high.
- R2: Register layout: bit 0 = software collapse request (1 = power down), bit 1 = hardware-trigger mode, bit 2 = wait override, [15:12] = clock-disable exponent, [19:16] = first-group exponent, [23:20] = second-group exponent, bit 31 = read-only status. All other bits read 0.
- R3: A collapse request is seen one cycle after the write edge: clock disable rises and status falls in that cycle. Clock disable alone lasts 2^[15:12] cycles, and the clamp then holds for 2^[15:12] cycles with the switches still on. After that, both switch enables drop together.
- R4: On restore, the first group is on alone for 2^[19:16] cycles. The second group then turns on, and the clamp stays until the acknowledge is high at least 2^[23:20] cycles later. The domain reset is low for exactly one cycle, with the clamp released and clocks still disabled. Clocks are then enabled together with status = 1.
- R5: Status is 1 only in the fully-on state. It reads 0 during every step of both sequences and while collapsed.
- R6: With bit 1 set, the hardware request input (1 = collapse) controls the domain and bit 0 has no effect.
- R7: A write to bit 1 is ignored while the stored bit 0 is 1.
- R8: An accepted change of bit 1 while on forces one complete collapse and restore cycle. Rewriting bit 1 with its current value does not.
- R9: With bit 2 set, every timed wait lasts one cycle.
- R10: A request that changes mid-sequence does not interrupt it. The running sequence completes, and then the new request is acted on.
- R11: The second switch group is never enabled while the first group is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| hw_req_i | input | 1 | Hardware collapse request (1 = collapse) |
| sw_ack_i | input | 1 | Switch fabric acknowledge (1 = powered) |
| few_sw_en_o | output | 1 | First switch group enable |
| rest_sw_en_o | output | 1 | Second switch group enable |
| clk_dis_o | output | 1 | Domain clock disable |
| clamp_o | output | 1 | Domain output clamp |
| dom_rst_no | output | 1 | Domain reset, active low |

## Verification
A register write is taken at one clock edge, and the sequencer reacts at the next edge. The bench therefore samples one falling edge after the write, where it expects the old state, and one edge later, where it expects the first step. After that it samples every falling edge and counts how many cycles each output combination lasts. It compares the counts with 2^n for the programmed exponents, or with 1 under override. The acknowledge comes from a one-flop model, so the clamp phase on restore is expected to last 2^n + 1 cycles. Mode-change and mid-sequence cases are given bounded windows for the collapse to appear and for status to return.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int unsigned SW_BIT   = 0;
  localparam int unsigned HW_BIT   = 1;
  localparam int unsigned OVR_BIT  = 2;
  localparam int unsigned CW_LSB   = 12;
  localparam int unsigned FW_LSB   = 16;
  localparam int unsigned RW_LSB   = 20;
  localparam int unsigned STAT_BIT = 31;

  typedef enum logic [3:0] {
    ST_ON, ST_DN_CLK, ST_DN_CLAMP, ST_DN_OFF, ST_OFF,
    ST_UP_FEW, ST_UP_REST, ST_UP_ACK, ST_UP_RST
  } seq_state_e;
endpackage

// File: rtl/pgc_regs.sv
module pgc_regs import pgc_pkg::*; #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             status_i,
  output logic [31:0]      rd_data_o,
  output logic             sw_collapse_o,
  output logic             hw_mode_o,
  output logic             override_o,
  output logic [EXP_W-1:0] cw_exp_o,
  output logic [EXP_W-1:0] fw_exp_o,
  output logic [EXP_W-1:0] rw_exp_o,
  output logic             mode_flip_o
);
  logic             sw_q, hw_q, ovr_q, flip_q;
  logic [EXP_W-1:0] cw_q, fw_q, rw_q;
  logic             unused_wbits;

  assign unused_wbits = ^{wr_data_i[11:3], wr_data_i[31:24]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= 1'b0;
      hw_q   <= 1'b0;
      ovr_q  <= 1'b0;
      cw_q   <= '0;
      fw_q   <= '0;
      rw_q   <= '0;
      flip_q <= 1'b0;
    end else begin
      flip_q <= wr_en_i && !sw_q && (wr_data_i[HW_BIT] != hw_q);
      if (wr_en_i) begin
        sw_q  <= wr_data_i[SW_BIT];
        ovr_q <= wr_data_i[OVR_BIT];
        cw_q  <= wr_data_i[CW_LSB +: EXP_W];
        fw_q  <= wr_data_i[FW_LSB +: EXP_W];
        rw_q  <= wr_data_i[RW_LSB +: EXP_W];
        // mode bit only moves while software votes for power
        if (!sw_q) hw_q <= wr_data_i[HW_BIT];
      end
    end
  end

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[SW_BIT]           = sw_q;
    rd_data_o[HW_BIT]           = hw_q;
    rd_data_o[OVR_BIT]          = ovr_q;
    rd_data_o[CW_LSB +: EXP_W]  = cw_q;
    rd_data_o[FW_LSB +: EXP_W]  = fw_q;
    rd_data_o[RW_LSB +: EXP_W]  = rw_q;
    rd_data_o[STAT_BIT]         = status_i;
  end

  assign sw_collapse_o = sw_q;
  assign hw_mode_o     = hw_q;
  assign override_o    = ovr_q;
  assign cw_exp_o      = cw_q;
  assign fw_exp_o      = fw_q;
  assign rw_exp_o      = rw_q;
  assign mode_flip_o   = flip_q;

  assert_hw_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sw_q) |=> $stable(hw_q));
endmodule

// File: rtl/pgc_wait_timer.sv
module pgc_wait_timer #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             bypass_i,
  output logic             done_o
);
  localparam int unsigned CNT_W = 1 << EXP_W;

  logic [CNT_W-1:0] cnt_q, limit;

  assign limit  = ~({CNT_W{1'b1}} << exp_i);
  // >= keeps a shortened field from stalling a running wait
  assign done_o = bypass_i || (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (!done_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pgc_seq.sv
module pgc_seq import pgc_pkg::*; #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_down_i,
  input  logic             flip_i,
  input  logic             sw_ack_i,
  input  logic             timer_done_i,
  input  logic [EXP_W-1:0] cw_exp_i,
  input  logic [EXP_W-1:0] fw_exp_i,
  input  logic [EXP_W-1:0] rw_exp_i,
  output logic [EXP_W-1:0] timer_exp_o,
  output logic             timer_clear_o,
  output logic             few_sw_en_o,
  output logic             rest_sw_en_o,
  output logic             clk_dis_o,
  output logic             clamp_o,
  output logic             dom_rst_no,
  output logic             status_o
);
  seq_state_e state_q, state_d;
  logic       pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON:       if (req_down_i || pend_q) state_d = ST_DN_CLK;
      ST_DN_CLK:   if (timer_done_i) state_d = ST_DN_CLAMP;
      ST_DN_CLAMP: if (timer_done_i) state_d = ST_DN_OFF;
      ST_DN_OFF:   if (!sw_ack_i) state_d = ST_OFF;
      ST_OFF:      if (!req_down_i) state_d = ST_UP_FEW;
      ST_UP_FEW:   if (timer_done_i) state_d = ST_UP_REST;
      ST_UP_REST:  if (timer_done_i) state_d = ST_UP_ACK;
      ST_UP_ACK:   if (sw_ack_i) state_d = ST_UP_RST;
      ST_UP_RST:   state_d = ST_ON;
      default:     state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flip_i) pend_q <= 1'b1;
      else if (state_q == ST_ON && state_d == ST_DN_CLK) pend_q <= 1'b0;
    end
  end

  assign timer_clear_o = (state_d != state_q);

  always_comb begin
    unique case (state_q)
      ST_UP_FEW:  timer_exp_o = fw_exp_i;
      ST_UP_REST: timer_exp_o = rw_exp_i;
      default:    timer_exp_o = cw_exp_i;
    endcase
  end

  always_comb begin
    few_sw_en_o  = 1'b1;
    rest_sw_en_o = 1'b1;
    clk_dis_o    = 1'b1;
    clamp_o      = 1'b1;
    dom_rst_no   = 1'b1;
    status_o     = 1'b0;
    unique case (state_q)
      ST_ON: begin
        clk_dis_o = 1'b0;
        clamp_o   = 1'b0;
        status_o  = 1'b1;
      end
      ST_DN_CLK:   clamp_o = 1'b0;
      ST_DN_OFF, ST_OFF: begin
        few_sw_en_o  = 1'b0;
        rest_sw_en_o = 1'b0;
      end
      ST_UP_FEW:   rest_sw_en_o = 1'b0;
      ST_UP_RST: begin
        clamp_o    = 1'b0;
        dom_rst_no = 1'b0;
      end
      default: ;
    endcase
  end

  assert_rest_needs_few_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rest_sw_en_o |-> few_sw_en_o);
  assert_clamp_after_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_o) |-> $past(clk_dis_o));
  assert_off_after_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(few_sw_en_o) |-> $past(clamp_o));
  assert_rst_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dom_rst_no) |=> $rose(dom_rst_no));
  assert_status_after_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(!dom_rst_no));
  assert_hold_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DN_CLAMP) |=> (state_q inside {ST_DN_CLAMP, ST_DN_OFF}));
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl import pgc_pkg::*; #(
  parameter int unsigned EXP_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        hw_req_i,
  input  logic        sw_ack_i,
  output logic        few_sw_en_o,
  output logic        rest_sw_en_o,
  output logic        clk_dis_o,
  output logic        clamp_o,
  output logic        dom_rst_no
);
  logic             sw_collapse, hw_mode, override_en, mode_flip, status;
  logic             req_down, t_clear, t_done;
  logic [EXP_W-1:0] cw_exp, fw_exp, rw_exp, t_exp;

  pgc_regs #(.EXP_W(EXP_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i       (reg_we_i),
    .wr_data_i     (reg_wdata_i),
    .status_i      (status),
    .rd_data_o     (reg_rdata_o),
    .sw_collapse_o (sw_collapse),
    .hw_mode_o     (hw_mode),
    .override_o    (override_en),
    .cw_exp_o      (cw_exp),
    .fw_exp_o      (fw_exp),
    .rw_exp_o      (rw_exp),
    .mode_flip_o   (mode_flip)
  );

  assign req_down = hw_mode ? hw_req_i : sw_collapse;

  pgc_wait_timer #(.EXP_W(EXP_W)) u_timer (
    .clk_i, .rst_ni,
    .clear_i  (t_clear),
    .exp_i    (t_exp),
    .bypass_i (override_en),
    .done_o   (t_done)
  );

  pgc_seq #(.EXP_W(EXP_W)) u_seq (
    .clk_i, .rst_ni,
    .req_down_i    (req_down),
    .flip_i        (mode_flip),
    .sw_ack_i      (sw_ack_i),
    .timer_done_i  (t_done),
    .cw_exp_i      (cw_exp),
    .fw_exp_i      (fw_exp),
    .rw_exp_i      (rw_exp),
    .timer_exp_o   (t_exp),
    .timer_clear_o (t_clear),
    .few_sw_en_o   (few_sw_en_o),
    .rest_sw_en_o  (rest_sw_en_o),
    .clk_dis_o     (clk_dis_o),
    .clamp_o       (clamp_o),
    .dom_rst_no    (dom_rst_no),
    .status_o      (status)
  );
endmodule

// File: tb/pwr_gate_ctrl_test.sv
module pwr_gate_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, hw_req = 1'b0, ack;
  logic [31:0] wdata = '0, rdata;
  logic        few, rest, cdis, clamp, drst_n;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwr_gate_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hw_req_i(hw_req), .sw_ack_i(ack),
    .few_sw_en_o(few), .rest_sw_en_o(rest), .clk_dis_o(cdis),
    .clamp_o(clamp), .dom_rst_no(drst_n)
  );

  // switch fabric model: acknowledge one cycle behind the second group
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ack <= 1'b1; else ack <= rest;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(int cw, int fw, int rw, bit ovr, bit hw, bit sw);
    return (32'(rw) << 20) | (32'(fw) << 16) | (32'(cw) << 12) |
           (32'(ovr) << 2) | (32'(hw) << 1) | 32'(sw);
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_status(input bit val, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      if (rdata[31] == val) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_few(input bit val, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      if (few == val) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  // entered at the falling edge right after the collapse write edge
  task automatic measure_down(input int exp_len);
    int na = 0, nb = 0, bad = 0, guard = 0;
    chk("R3 old state one edge after write", {cdis, rdata[31]}, 2'b01);
    @(negedge clk);
    chk("R3 clocks off first", {cdis, clamp}, 2'b10);
    while (few && guard < 70000) begin
      if (!clamp) na++; else nb++;
      if (rdata[31]) bad++;
      guard++;
      @(negedge clk);
    end
    chk("R3 clock-disable phase length", na, exp_len);
    chk("R3 clamp phase length", nb, exp_len);
    chk("R3 switches drop together", {few, rest, clamp, cdis}, 4'b0011);
    chk("R5 status low while collapsing", bad, 0);
  endtask

  task automatic measure_up(input int exp_f, input int exp_r);
    int nf = 0, nr = 0, nrst = 0, other = 0, bad = 0, guard = 0;
    chk("R5 status low while collapsed", rdata[31], 0);
    @(negedge clk);
    while (!rdata[31] && guard < 70000) begin
      if (few && !rest) nf++;
      else if (rest && clamp) nr++;
      else if (!drst_n) begin
        nrst++;
        if (!cdis || clamp) bad++;
      end else other++;
      guard++;
      @(negedge clk);
    end
    chk("R4 first group phase length", nf, exp_f);
    chk("R4 clamp held through second group and ack", nr, exp_r);
    chk("R4 reset pulse one cycle", nrst, 1);
    chk("R4 reset with clamp off and clocks off", bad, 0);
    chk("R5 no other transit state", other, 0);
    chk("R4 fully on at status", {few, rest, cdis, clamp, drst_n}, 5'b11001);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk("R1 reset register", rdata, 32'h8000_0000);
    chk("R1 reset outputs", {few, rest, cdis, clamp, drst_n}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep of step waits
    for (int cw = 0; cw < 4; cw++)
      for (int fw = 0; fw < 4; fw++)
        for (int rw = 0; rw < 3; rw++) begin
          wr(word(cw, fw, rw, 0, 0, 1));
          measure_down(1 << cw);
          wr(word(cw, fw, rw, 0, 0, 0));
          measure_up(1 << fw, (1 << rw) + 1);
        end

    // suggested programming
    wr(word(2, 8, 2, 0, 0, 1));
    measure_down(4);
    wr(word(2, 8, 2, 0, 0, 0));
    measure_up(256, 5);

    // R9 override
    wr(word(3, 3, 3, 1, 0, 1));
    measure_down(1);
    wr(word(3, 3, 3, 1, 0, 0));
    measure_up(1, 2);

    // R10 request reversed during collapse
    wr(word(2, 1, 1, 0, 0, 1));
    @(negedge clk); @(negedge clk);
    wr(word(2, 1, 1, 0, 0, 0));
    wait_few(0, 100, ok);
    chk("R10 collapse completes before restore", ok, 1);
    wait_status(1, 200, ok);
    chk("R10 restore follows", ok, 1);
    // R10 request reversed during restore
    wr(word(1, 3, 1, 0, 0, 1));
    wait_few(0, 100, ok);
    wr(word(1, 3, 1, 0, 0, 0));
    @(negedge clk); @(negedge clk);
    wr(word(1, 3, 1, 0, 0, 1));
    wait_status(1, 200, ok);
    chk("R10 restore completes before collapse", ok, 1);
    wait_few(0, 200, ok);
    chk("R10 collapse follows", ok, 1);

    // R7 mode write ignored while collapse is stored
    wr(word(1, 1, 1, 0, 1, 1));
    repeat (20) @(negedge clk);
    chk("R7 mode bit stays clear", rdata[1], 0);
    chk("R7 domain stays off", few, 0);
    wr(word(1, 1, 1, 0, 0, 0));
    wait_status(1, 200, ok);
    chk("R7 restore after ignored write", ok, 1);

    // R8 entering hardware mode cycles the domain
    wr(word(1, 1, 1, 0, 1, 0));
    chk("R2 mode bit read back", rdata[1], 1);
    wait_few(0, 100, ok);
    chk("R8 mode change collapses", ok, 1);
    wait_status(1, 200, ok);
    chk("R8 mode change restores", ok, 1);
    wr(word(1, 1, 1, 0, 1, 0));
    repeat (30) @(negedge clk);
    chk("R8 same mode value causes no cycle", {few, rdata[31]}, 2'b11);

    // R6 hardware request owns the domain
    wr(word(1, 1, 1, 0, 1, 1));
    repeat (30) @(negedge clk);
    chk("R6 software collapse ignored", {few, rdata[31]}, 2'b11);
    @(negedge clk); hw_req = 1'b1;
    wait_few(0, 100, ok);
    chk("R6 hardware collapse", ok, 1);
    repeat (10) @(negedge clk);
    chk("R6 stays collapsed", rdata[31], 0);
    hw_req = 1'b0;
    wait_status(1, 200, ok);
    chk("R6 hardware restore", ok, 1);
    wr(word(1, 1, 1, 0, 1, 0));
    wr(word(1, 1, 1, 0, 0, 0));
    wait_few(0, 100, ok);
    chk("R8 leaving hardware mode collapses", ok, 1);
    wait_status(1, 200, ok);
    chk("R8 leaving hardware mode restores", ok, 1);

    // R2 layout with junk bits
    wr(32'h7FFF_FFFE);
    chk("R2 field read back", rdata & 32'h7FFF_FFFF, 32'h00FF_F006);
    wait_status(1, 200, ok);
    chk("R2 status bit after cycle", rdata[31], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule